// File: doc/BRIEF.md
# Synchronous Burst Memory Read Sequencer

This block runs synchronous burst reads against a NOR flash or cellular-RAM device. A client places a start byte address and a word count on a request port. The sequencer then does five things in order:

- It derives a memory clock from the system clock.
- It selects the device and presents the address, marked by an address-valid strobe.
- It lets a programmable number of latency clocks pass.
- It samples one data word on every rising memory clock edge until the requested count is reached.
- It emits each word on a one-cycle valid stream, followed by a done pulse.

A wait input from the device can hold off sampling. Its polarity and its timing are both configurable. A burst that would run across a configured page boundary is closed and reopened at the next page address.

Configuration inputs are static while a burst is in flight. They only change while the block is idle.

Top module: `burst_rd_seq`

## Requirements
- R1: The memory clock period is P = `cfg_div` clamped to 2..16 system cycles. In each period the clock is high for the first floor(P/2) cycles and low for the rest. With `cfg_cont_clk` = 0 the clock is held low while no burst is active.
- R2: With `cfg_cont_clk` = 1 the memory clock keeps toggling at period P while idle. A new burst then waits for the next memory clock rising edge before presenting its address.
- R3: `req_ready` is high only while idle. A request is taken on a cycle with `req_valid` and `req_ready` both high, and it reads `req_len`+1 words. After reset the block is idle with `mem_ce_n`, `mem_adv_n` high and `mem_clk`, `rd_valid`, `done` low.
- R4: `mem_adv_n` is low for exactly one memory clock period, starting on a memory clock rising edge, at the start of every burst and every split sub-burst. `mem_ce_n` is low from the strobe until the word that ends the (sub-)burst is sampled.
- R5: After the address clock, L latency clocks pass. L = `cfg_lat` clamped to 2..17 when `cfg_cram` = 0, and L = 0 when `cfg_cram` = 1. With `cfg_cont_clk` = 0 and no wait, the first `rd_valid` is seen 1+(L+2)·P system cycles after the accepting edge.
- R6: In the data phase `mem_dq` is sampled at each memory clock rising edge that is not stalled. Each sampled word appears on `rd_data` with a one-cycle `rd_valid` in the following system cycle.
- R7: With `cfg_wait_en` = 1, wait is active when `mem_wait` equals `cfg_wait_hi` (1 = active high, 0 = active low). An active wait skips the sample and does not count a word. With `cfg_wait_en` = 0, `mem_wait` is ignored.
- R8: With `cfg_wait_early` = 0, a wait value sampled at an edge stalls that same edge. With `cfg_wait_early` = 1, it stalls the next data edge, and the first data edge of each sub-burst is never stalled.
- R9: `cfg_page` selects the page size: 1 = 128, 2 = 256, 3 = 512 and 4 = 1024 bytes; 0 and 5..7 = no splitting. Suppose a word that is not the last one is sampled and the next address is a multiple of the page size. Then `mem_ce_n` goes high for one memory clock, and a new strobe and latency phase follow at that next address.
- R10: `mem_addr` starts at `req_addr` and advances by DW/8 bytes for every sampled word.
- R11: `done` pulses for one cycle, one system cycle after the `rd_valid` of the final word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request present |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Word count minus one |
| req_ready | output | 1 | Idle, request can be taken |
| cfg_div | input | 5 | Memory clock period in system cycles |
| cfg_lat | input | 5 | First-data latency in memory clocks (flash) |
| cfg_cram | input | 1 | Cellular-RAM mode, latency forced to zero |
| cfg_cont_clk | input | 1 | Keep memory clock running when idle |
| cfg_wait_en | input | 1 | Honour the wait input |
| cfg_wait_hi | input | 1 | Wait active level |
| cfg_wait_early | input | 1 | Wait announced one data clock ahead |
| cfg_page | input | 3 | Page size select for burst splitting |
| mem_clk | output | 1 | Memory clock |
| mem_ce_n | output | 1 | Device select, active low |
| mem_adv_n | output | 1 | Address-valid strobe, active low |
| mem_addr | output | AW | Memory byte address |
| mem_dq | input | DW | Read data from memory |
| mem_wait | input | 1 | Wait from memory |
| rd_valid | output | 1 | Sampled word valid |
| rd_data | output | DW | Sampled word |
| done | output | 1 | Burst finished |

## Verification
The clock divider is driven at even, odd and clamped periods. This separates the high/low split and the clamp rules from the simple case. Latency is exercised in flash mode at small, clamped-low and clamped-high values, and in cellular-RAM mode, so the first-word delay shows whether the latency count or the mode override is in force.

Wait is exercised with both polarities and both timings against a repeating wait pattern. This tells a same-edge stall apart from a next-edge stall. Page splitting is exercised with each size, with splitting off, and with a boundary reached exactly on the last word. These cases separate a real split from a spurious extra strobe.

A behavioural model compares every output on every cycle.

// File: rtl/brs_pkg.sv
package brs_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARM,
    S_ADDR,
    S_LAT,
    S_DATA,
    S_GAP
  } brs_state_e;

  function automatic logic [4:0] div_clamp(input logic [4:0] d);
    if (d < 5'd2)  return 5'd2;
    if (d > 5'd16) return 5'd16;
    return d;
  endfunction

  function automatic logic [4:0] lat_clamp(input logic [4:0] l);
    if (l < 5'd2)  return 5'd2;
    if (l > 5'd17) return 5'd17;
    return l;
  endfunction

endpackage

// File: rtl/brs_clkgen.sv
module brs_clkgen #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] period,
  output logic          tick,
  output logic          mem_clk
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  // tick marks the last system cycle of a memory clock period
  assign tick    = run && (cnt_q == period - CW'(1));
  assign mem_clk = run && (cnt_q < (period >> 1));

  always_comb begin
    if (!run || tick) cnt_d = '0;
    else              cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: phase counter never leaves the programmed period
  a_r1_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < period);

endmodule

// File: rtl/brs_page_edge.sv
module brs_page_edge #(
  parameter int NSIZE  = 4,
  parameter int MINLOG = 7,
  localparam int TOPB  = MINLOG + NSIZE - 2
) (
  input  logic [TOPB:0] nxt,
  input  logic [2:0]    sel,
  output logic          hit
);

  logic [NSIZE-1:0] at_edge;

  for (genvar g = 0; g < NSIZE; g++) begin : g_size
    assign at_edge[g] = (nxt[MINLOG-1+g:0] == '0);
  end

  always_comb begin
    hit = 1'b0;
    if (sel != 3'd0 && int'(sel) <= NSIZE) hit = at_edge[sel-3'd1];
  end

endmodule

// File: rtl/burst_rd_seq.sv
module burst_rd_seq
  import brs_pkg::*;
#(
  parameter int AW = 24,
  parameter int DW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  output logic          req_ready,
  input  logic [4:0]    cfg_div,
  input  logic [4:0]    cfg_lat,
  input  logic          cfg_cram,
  input  logic          cfg_cont_clk,
  input  logic          cfg_wait_en,
  input  logic          cfg_wait_hi,
  input  logic          cfg_wait_early,
  input  logic [2:0]    cfg_page,
  output logic          mem_clk,
  output logic          mem_ce_n,
  output logic          mem_adv_n,
  output logic [AW-1:0] mem_addr,
  input  logic [DW-1:0] mem_dq,
  input  logic          mem_wait,
  output logic          rd_valid,
  output logic [DW-1:0] rd_data,
  output logic          done
);

  localparam int STEP   = DW / 8;
  localparam int NSIZE  = 4;
  localparam int MINLOG = 7;
  localparam int PTOP   = MINLOG + NSIZE - 2;

  brs_state_e    st_q, st_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] left_q, left_d;
  logic [4:0]    lat_q, lat_d;
  logic          wdly_q, wdly_d;
  logic          vld_q, vld_d;
  logic [DW-1:0] dat_q, dat_d;
  logic          fin_q, fin_d;
  logic          done_q;

  logic [4:0]    period;
  logic [4:0]    lat_eff;
  logic          run;
  logic          tick;
  logic          wait_now;
  logic          stall;
  logic          edge_hit;
  logic [AW-1:0] addr_inc;

  assign period   = div_clamp(cfg_div);
  assign lat_eff  = cfg_cram ? 5'd0 : lat_clamp(cfg_lat);
  assign run      = cfg_cont_clk || (st_q inside {S_ADDR, S_LAT, S_DATA, S_GAP});
  assign addr_inc = addr_q + AW'(STEP);
  assign wait_now = cfg_wait_en && (mem_wait == cfg_wait_hi);
  assign stall    = cfg_wait_early ? wdly_q : wait_now;

  brs_clkgen #(.CW(5)) u_clk (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .period  (period),
    .tick    (tick),
    .mem_clk (mem_clk)
  );

  brs_page_edge #(.NSIZE(NSIZE), .MINLOG(MINLOG)) u_page (
    .nxt (addr_inc[PTOP:0]),
    .sel (cfg_page),
    .hit (edge_hit)
  );

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    left_d = left_q;
    lat_d  = lat_q;
    wdly_d = wdly_q;
    vld_d  = 1'b0;
    dat_d  = dat_q;
    fin_d  = 1'b0;
    unique case (st_q)
      S_IDLE: begin
        if (req_valid) begin
          addr_d = req_addr;
          left_d = req_len;
          st_d   = S_ARM;
        end
      end
      S_ARM: begin
        if (!cfg_cont_clk || tick) st_d = S_ADDR;
      end
      S_ADDR: begin
        if (tick) begin
          if (lat_eff == 5'd0) begin
            st_d   = S_DATA;
            wdly_d = 1'b0;
          end else begin
            lat_d = lat_eff - 5'd1;
            st_d  = S_LAT;
          end
        end
      end
      S_LAT: begin
        if (tick) begin
          if (lat_q == 5'd0) begin
            st_d   = S_DATA;
            wdly_d = 1'b0;
          end else begin
            lat_d = lat_q - 5'd1;
          end
        end
      end
      S_DATA: begin
        if (tick) begin
          wdly_d = wait_now;
          if (!stall) begin
            vld_d  = 1'b1;
            dat_d  = mem_dq;
            addr_d = addr_inc;
            if (left_q == '0) begin
              st_d  = S_IDLE;
              fin_d = 1'b1;
            end else begin
              left_d = left_q - LW'(1);
              if (edge_hit) st_d = S_GAP;
            end
          end
        end
      end
      S_GAP: begin
        if (tick) st_d = S_ADDR;
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      left_q <= '0;
      lat_q  <= '0;
      wdly_q <= 1'b0;
      vld_q  <= 1'b0;
      dat_q  <= '0;
      fin_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      left_q <= left_d;
      lat_q  <= lat_d;
      wdly_q <= wdly_d;
      vld_q  <= vld_d;
      dat_q  <= dat_d;
      fin_q  <= fin_d;
      done_q <= fin_q;
    end
  end

  assign req_ready = (st_q == S_IDLE);
  assign mem_ce_n  = !(st_q inside {S_ADDR, S_LAT, S_DATA});
  assign mem_adv_n = (st_q != S_ADDR);
  assign mem_addr  = addr_q;
  assign rd_valid  = vld_q;
  assign rd_data   = dat_q;
  assign done      = done_q;

  // R4: strobe opens on a memory clock rising edge
  a_r4_adv_opens_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_adv_n) |-> $rose(mem_clk));

  // R4: strobe closes after a whole memory clock, at the next rising edge
  a_r4_adv_closes_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_adv_n) |-> $rose(mem_clk));

  // R3: an accepted request leaves the idle state
  a_r3_accept_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R10: every delivered word advanced the address by one word
  a_r10_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (mem_addr == $past(mem_addr) + AW'(STEP)));

  // R11: done comes right after a delivered word
  a_r11_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(rd_valid));

endmodule

// File: tb/sim_burst_rd_seq.sv
module sim_burst_rd_seq;
  localparam int AW = 24;
  localparam int DW = 16;
  localparam int LW = 8;
  localparam int STEP = DW / 8;

  logic clk = 1'b0;
  logic rst_n;
  always #4 clk = ~clk;

  logic          req_valid;
  logic [AW-1:0] req_addr;
  logic [LW-1:0] req_len;
  logic          req_ready;
  logic [4:0]    cfg_div, cfg_lat;
  logic          cfg_cram, cfg_cont_clk, cfg_wait_en, cfg_wait_hi, cfg_wait_early;
  logic [2:0]    cfg_page;
  logic          mem_clk, mem_ce_n, mem_adv_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq;
  logic          mem_wait;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic          done;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit chk_on = 0;

  burst_rd_seq #(.AW(AW), .DW(DW), .LW(LW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .req_ready(req_ready), .cfg_div(cfg_div), .cfg_lat(cfg_lat),
    .cfg_cram(cfg_cram), .cfg_cont_clk(cfg_cont_clk), .cfg_wait_en(cfg_wait_en),
    .cfg_wait_hi(cfg_wait_hi), .cfg_wait_early(cfg_wait_early), .cfg_page(cfg_page),
    .mem_clk(mem_clk), .mem_ce_n(mem_ce_n), .mem_adv_n(mem_adv_n), .mem_addr(mem_addr),
    .mem_dq(mem_dq), .mem_wait(mem_wait), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // memory stand-in: data is a running count, wait follows a fixed pattern
  always @(negedge clk) begin
    mem_dq   <= 16'(cyc);
    mem_wait <= ((cyc % 7) < 3);
  end

  function automatic int per_now();
    if (cfg_div < 2)  return 2;
    if (cfg_div > 16) return 16;
    return int'(cfg_div);
  endfunction

  function automatic int lat_now();
    if (cfg_cram) return 0;
    if (cfg_lat < 2)  return 2;
    if (cfg_lat > 17) return 17;
    return int'(cfg_lat);
  endfunction

  function automatic bit page_hit(input logic [AW-1:0] a);
    int s;
    s = int'(cfg_page);
    if (s < 1 || s > 4) return 0;
    return (int'(a) % (64 << s)) == 0;
  endfunction

  // behavioural reference: 0 idle, 1 arm, 2 address, 3 latency, 4 data, 5 gap
  int            m_st, m_cnt, m_left, m_lat;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_dat;
  bit            m_wd, m_vld, m_fin, m_done;

  always @(posedge clk or negedge rst_n) begin : mdl
    int p;
    bit on, tk, wn, stl;
    logic [AW-1:0] na;
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_left = 0; m_lat = 0; m_addr = '0; m_dat = '0;
      m_wd = 0; m_vld = 0; m_fin = 0; m_done = 0;
    end else begin
      p  = per_now();
      on = cfg_cont_clk || (m_st >= 2);
      tk = on && (m_cnt == p - 1);
      m_cnt  = (!on || tk) ? 0 : m_cnt + 1;
      m_done = m_fin;
      m_fin  = 0;
      m_vld  = 0;
      case (m_st)
        0: if (req_valid) begin m_addr = req_addr; m_left = int'(req_len); m_st = 1; end
        1: if (!cfg_cont_clk || tk) m_st = 2;
        2: if (tk) begin
             if (lat_now() == 0) begin m_st = 4; m_wd = 0; end
             else begin m_lat = lat_now() - 1; m_st = 3; end
           end
        3: if (tk) begin
             if (m_lat == 0) begin m_st = 4; m_wd = 0; end
             else m_lat = m_lat - 1;
           end
        4: if (tk) begin
             wn  = cfg_wait_en && (mem_wait == cfg_wait_hi);
             stl = cfg_wait_early ? m_wd : wn;
             m_wd = wn;
             if (!stl) begin
               m_vld = 1; m_dat = mem_dq;
               na = m_addr + AW'(STEP);
               m_addr = na;
               if (m_left == 0) begin m_st = 0; m_fin = 1; end
               else begin
                 m_left = m_left - 1;
                 if (page_hit(na)) m_st = 5;
               end
             end
           end
        5: if (tk) m_st = 2;
        default: m_st = 0;
      endcase
    end
  end

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin : cmp
    bit e_on, e_clk, e_ce, e_adv, e_rdy;
    logic [AW+DW+5:0] av, ev;
    if (rst_n && chk_on) begin
      e_on  = cfg_cont_clk || (m_st >= 2);
      e_clk = e_on && (m_cnt < per_now() / 2);
      e_ce  = !(m_st == 2 || m_st == 3 || m_st == 4);
      e_adv = (m_st != 2);
      e_rdy = (m_st == 0);
      av = {mem_clk, mem_ce_n, mem_adv_n, req_ready, rd_valid, done, mem_addr, rd_data};
      ev = {e_clk, e_ce, e_adv, e_rdy, m_vld, m_done, m_addr, m_vld ? m_dat : rd_data};
      n_run++;
      if (av !== ev) begin
        n_fail++;
        if (mem_clk !== e_clk)
          $display("FAIL R1 clock at cycle %0d: act=%h exp=%h", cyc, av, ev);
        else if (mem_ce_n !== e_ce || mem_adv_n !== e_adv)
          $display("FAIL R4 select/strobe at cycle %0d: act=%h exp=%h", cyc, av, ev);
        else if (req_ready !== e_rdy)
          $display("FAIL R3 ready at cycle %0d: act=%h exp=%h", cyc, av, ev);
        else if (mem_addr !== m_addr)
          $display("FAIL R10 address at cycle %0d: act=%h exp=%h", cyc, av, ev);
        else if (done !== m_done)
          $display("FAIL R11 done at cycle %0d: act=%h exp=%h", cyc, av, ev);
        else
          $display("FAIL R6 data stream at cycle %0d: act=%h exp=%h", cyc, av, ev);
      end
    end
  end

  // output event counters
  int  tot_vld = 0, tot_done = 0, tot_adv = 0;
  bit  prev_adv = 1;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rd_valid) tot_vld++;
      if (done) tot_done++;
      if (prev_adv && !mem_adv_n) tot_adv++;
      prev_adv = mem_adv_n;
    end
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: act=%0d exp=%0d", what, act, exp);
    end
  endtask

  task automatic config_set(input int dv, input int lt, input bit cram, input bit cont,
                            input bit wen, input bit whi, input bit wearly, input int pg);
    @(posedge clk); chk_on = 0;
    @(negedge clk); cfg_cont_clk = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    cfg_div = 5'(dv); cfg_lat = 5'(lt); cfg_cram = cram; cfg_wait_en = wen;
    cfg_wait_hi = whi; cfg_wait_early = wearly; cfg_page = 3'(pg); cfg_cont_clk = cont;
    @(posedge clk); @(posedge clk); chk_on = 1;
  endtask

  task automatic burst(input int a, input int len, input int exp_first, input int exp_adv,
                       input string tag);
    int v0, d0, s0, k, fk;
    @(negedge clk);
    chk(req_ready === 1'b1, {"R3 ready before request ", tag}, int'(req_ready), 1);
    v0 = tot_vld; d0 = tot_done; s0 = tot_adv;
    req_valid = 1; req_addr = AW'(a); req_len = LW'(len);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    k = 0; fk = -1;
    while (tot_done == d0 && k < 6000) begin
      if (rd_valid && fk < 0) fk = k;
      @(negedge clk); k++;
    end
    if (rd_valid && fk < 0) fk = k;
    chk(k < 6000, {"R11 burst finished in time ", tag}, k, 6000);
    repeat (3) @(negedge clk);
    chk(tot_vld - v0 == len + 1, {"R6 word count ", tag}, tot_vld - v0, len + 1);
    chk(tot_done - d0 == 1, {"R11 one done pulse ", tag}, tot_done - d0, 1);
    chk(tot_adv - s0 == exp_adv, {"R9 strobe count ", tag}, tot_adv - s0, exp_adv);
    if (exp_first >= 0)
      chk(fk == exp_first, {"R5 first word delay ", tag}, fk, exp_first);
  endtask

  task automatic count_rises(input int span, output int rises);
    bit pv;
    rises = 0;
    @(negedge clk); pv = mem_clk;
    for (int i = 0; i < span; i++) begin
      @(negedge clk);
      if (mem_clk && !pv) rises++;
      pv = mem_clk;
    end
  endtask

  initial begin : wdog
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    int r;
    rst_n = 0; req_valid = 0; req_addr = '0; req_len = '0;
    cfg_div = 5'd4; cfg_lat = 5'd3; cfg_cram = 0; cfg_cont_clk = 0;
    cfg_wait_en = 0; cfg_wait_hi = 1; cfg_wait_early = 0; cfg_page = 3'd0;
    mem_dq = '0; mem_wait = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R3: idle state after reset
    chk(req_ready === 1'b1 && mem_ce_n === 1'b1 && mem_adv_n === 1'b1 &&
        rd_valid === 1'b0 && done === 1'b0 && mem_clk === 1'b0,
        "R3 reset state", int'({req_ready, mem_ce_n, mem_adv_n, rd_valid, done, mem_clk}), 'b111000);
    chk_on = 1;

    // R1/R5: flash, period 4, latency 3
    config_set(4, 3, 0, 0, 0, 1, 0, 0);
    count_rises(20, r);
    chk(r == 0, "R1 clock stopped while idle", r, 0);
    burst('h100, 3, 1 + 5 * 4, 1, "div4 lat3");
    // R1/R5: both clamps at the low end
    config_set(0, 0, 0, 0, 0, 1, 0, 0);
    burst('h2000, 7, 1 + 4 * 2, 1, "div2 lat2 clamped");
    // R5: cellular-RAM mode ignores latency, odd period
    config_set(3, 9, 1, 0, 0, 1, 0, 0);
    burst('h40, 5, 1 + 2 * 3, 1, "cram div3");
    // R1/R5: clamps at the high end
    config_set(20, 25, 0, 0, 0, 1, 0, 0);
    burst('h10, 1, 1 + 19 * 16, 1, "div16 lat17 clamped");
    // R7: wait input ignored when disabled
    config_set(2, 2, 0, 0, 0, 1, 0, 0);
    burst('h300, 9, 1 + 4 * 2, 1, "R7 wait disabled");
    // R7/R8: active-high wait on the same edge
    config_set(2, 2, 0, 0, 1, 1, 0, 0);
    burst('h400, 15, -1, 1, "R7 R8 wait high late");
    // R7/R8: active-low wait announced one edge early
    config_set(3, 2, 0, 0, 1, 0, 1, 0);
    burst('h500, 11, -1, 1, "R7 R8 wait low early");
    // R9: each page size, splitting off, and a boundary on the last word
    config_set(2, 2, 0, 0, 0, 1, 0, 1);
    burst('h78, 5, -1, 2, "R9 128 split");
    burst('h7C, 1, -1, 1, "R9 boundary on last word");
    config_set(2, 2, 0, 0, 0, 1, 0, 2);
    burst('h1F8, 9, -1, 2, "R9 256 split");
    config_set(3, 2, 1, 0, 0, 1, 0, 3);
    burst('h5FE, 1, -1, 2, "R9 512 split cram");
    config_set(2, 2, 0, 0, 1, 1, 1, 4);
    burst('h3FC, 3, -1, 2, "R9 1024 split with wait");
    config_set(2, 2, 0, 0, 0, 1, 0, 0);
    burst('h3FC, 3, -1, 1, "R9 no split");
    // R2: continuous clock, odd period 5
    config_set(5, 2, 0, 1, 0, 1, 0, 0);
    count_rises(20, r);
    chk(r == 4, "R2 clock runs while idle", r, 4);
    burst('h800, 3, -1, 1, "R2 continuous clock");
    burst('h801, 2, -1, 1, "R2 continuous clock again");

    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule